// File: doc/BRIEF.md
# Watchdog Timer with Selectable Timeout Response

This block is a down-counting watchdog for a small microcontroller. A 24-bit counter is loaded from a reload value supplied by the register file. It counts down once per enabled watchdog tick. Software must strobe a refresh before the count runs out. When a tick finds the counter at zero, the watchdog has timed out. A configuration bit then picks the response: either a one-cycle exception request to the interrupt controller, or a reset request that stays asserted.

When the exception response is selected and the device sits in its low-power stop state, a timeout also raises a wake-up request. It sets a stop-related status flag next to the ordinary timeout flag. Both flags are sticky and feed a reset status register, which clears them with a read-clear strobe. While a debugger holds the debug input high, the counter is reloaded on every cycle, so the part never times out while halted.

Top module: `wdog_top`

## Requirements
- R1: Synchronous reset sets the counter to 0x00FFFF and drives every output low. If `wd_enable` is already high when reset releases, counting starts from 0x00FFFF and no load from `reload_val` takes place. With a tick on every cycle, the first timeout then occurs on the 65536th tick.
- R2: A rising edge of `wd_enable` loads the counter from `reload_val`, and that cycle's tick is not counted. While `wd_enable` is low, the counter holds its value and no timeout can occur.
- R3: With the watchdog enabled, each cycle with `tick` high decrements the counter. A tick that finds the counter at zero is a timeout, and the counter reloads from `reload_val` in the same cycle. A reload value N therefore gives a timeout on every (N+1)th tick.
- R4: `refresh` reloads the counter from `reload_val` and wins over a tick in the same cycle. A refresh that coincides with a zero-count tick produces no timeout.
- R5: While `debug_hold` is high, the enabled counter reloads every cycle and no timeout occurs.
- R6: With `resp_sel` = 0 (exception response), a timeout makes `exc_req` high for exactly the cycle after the timeout tick. `reset_req` stays low.
- R7: With `resp_sel` = 0 and `stop_mode` high at the timeout tick, `wake_req` pulses together with `exc_req`, and both `flag_timeout` and `flag_stop` are set.
- R8: With `resp_sel` = 1 (reset response), a timeout raises `reset_req`, which stays high until synchronous reset. It also sets `flag_timeout`, and it neither pulses `exc_req` nor sets `flag_stop`.
- R9: `flag_timeout` and `flag_stop` stay set until `status_clr` is high for one cycle. A timeout in the same cycle as `status_clr` leaves the flag it sets at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_enable | input | 1 | Watchdog enable; a rising edge loads the counter |
| tick | input | 1 | Watchdog count tick (clock enable) |
| reload_val | input | 24 | Reload value from the register file |
| refresh | input | 1 | Refresh strobe from the CPU |
| debug_hold | input | 1 | Debug halt: refresh every cycle |
| stop_mode | input | 1 | Device is in the low-power stop state |
| resp_sel | input | 1 | Timeout response: 0 exception, 1 reset |
| status_clr | input | 1 | Read-clear strobe for the status flags |
| exc_req | output | 1 | One-cycle exception request |
| wake_req | output | 1 | One-cycle stop-recovery request |
| reset_req | output | 1 | Device reset request, held until reset |
| flag_timeout | output | 1 | Sticky watchdog timeout status |
| flag_stop | output | 1 | Sticky timeout-in-stop status |

## Verification
The hardest case to reach from the ports is a timeout counted from the reset value. This path skips the reload value completely, so it shows only after 65536 ticks with enable held through reset. The bench drives exactly that run as a directed case. A second hard case is a refresh landing on the very tick that finds the counter at zero. Random phases use reload values below 16 and frequent ticks, so zero-count ticks are common and collide with refresh, debug, stop and clear strobes. A cycle-accurate bench model predicts every output.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int WD_CNT_W = 24;
    localparam logic [WD_CNT_W-1:0] WD_RESET_COUNT = 24'h00FFFF;

    typedef enum logic {
        RESP_EXC = 1'b0,
        RESP_RST = 1'b1
    } resp_e;

    typedef struct packed {
        logic fire;
        logic in_stop;
        logic sel_rst;
    } tmo_evt_t;

    function automatic logic is_zero(input logic [WD_CNT_W-1:0] v);
        return v == '0;
    endfunction

endpackage

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int CNT_W = WD_CNT_W,
    parameter logic [CNT_W-1:0] RESET_COUNT = WD_RESET_COUNT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wd_enable,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             refresh,
    input  logic             debug_hold,
    input  logic             stop_mode,
    input  logic             resp_sel,
    output tmo_evt_t         evt
);

    logic [CNT_W-1:0] count_q;
    logic             en_q;
    logic             first_load;
    logic             forced_load;
    logic             at_zero;
    logic             fire;

    assign first_load  = wd_enable && !en_q;
    assign forced_load = wd_enable && en_q && (refresh || debug_hold);
    assign at_zero     = (count_q == '0);
    assign fire        = wd_enable && en_q && !refresh && !debug_hold && tick && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= RESET_COUNT;
            en_q    <= 1'b1;
        end else begin
            en_q <= wd_enable;
            if (first_load || forced_load || fire) begin
                count_q <= reload_val;
            end else if (wd_enable && tick) begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    always_comb begin
        evt.fire    = fire;
        evt.in_stop = stop_mode;
        evt.sel_rst = (resp_e'(resp_sel) == RESP_RST);
    end

    AST_DEBUG_RELOADS: assert property (@(posedge clk) disable iff (rst)
        (wd_enable && en_q && debug_hold) |=> (count_q == $past(reload_val))); // R5

    AST_REFRESH_RELOADS: assert property (@(posedge clk) disable iff (rst)
        (wd_enable && en_q && refresh) |=> (count_q == $past(reload_val))); // R4

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!wd_enable && !$past(rst)) |=> $stable(count_q)); // R2

endmodule

// File: rtl/wdog_response.sv
module wdog_response
    import wdog_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tmo_evt_t evt,
    input  logic     status_clr,
    output logic     exc_req,
    output logic     wake_req,
    output logic     reset_req,
    output logic     flag_timeout,
    output logic     flag_stop
);

    logic exc_hit;
    logic stop_hit;

    assign exc_hit  = evt.fire && !evt.sel_rst;
    assign stop_hit = exc_hit && evt.in_stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_req      <= 1'b0;
            wake_req     <= 1'b0;
            reset_req    <= 1'b0;
            flag_timeout <= 1'b0;
            flag_stop    <= 1'b0;
        end else begin
            exc_req   <= exc_hit;
            wake_req  <= stop_hit;
            reset_req <= reset_req || (evt.fire && evt.sel_rst);
            if (evt.fire) begin
                flag_timeout <= 1'b1;
            end else if (status_clr) begin
                flag_timeout <= 1'b0;
            end
            if (stop_hit) begin
                flag_stop <= 1'b1;
            end else if (status_clr) begin
                flag_stop <= 1'b0;
            end
        end
    end

    AST_RESET_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> reset_req); // R8

    AST_WAKE_WITH_EXC: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> (exc_req && flag_stop)); // R7

    AST_STOP_FLAG_PAIRED: assert property (@(posedge clk) disable iff (rst)
        flag_stop |-> flag_timeout); // R9

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (status_clr && !evt.fire) |=> !flag_timeout); // R9

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int CNT_W = WD_CNT_W,
    parameter logic [CNT_W-1:0] RESET_COUNT = WD_RESET_COUNT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wd_enable,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             refresh,
    input  logic             debug_hold,
    input  logic             stop_mode,
    input  logic             resp_sel,
    input  logic             status_clr,
    output logic             exc_req,
    output logic             wake_req,
    output logic             reset_req,
    output logic             flag_timeout,
    output logic             flag_stop
);

    tmo_evt_t evt;

    wdog_counter #(
        .CNT_W      (CNT_W),
        .RESET_COUNT(RESET_COUNT)
    ) cnt_i (
        .clk        (clk),
        .rst        (rst),
        .wd_enable  (wd_enable),
        .tick       (tick),
        .reload_val (reload_val),
        .refresh    (refresh),
        .debug_hold (debug_hold),
        .stop_mode  (stop_mode),
        .resp_sel   (resp_sel),
        .evt        (evt)
    );

    wdog_response rsp_i (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .status_clr   (status_clr),
        .exc_req      (exc_req),
        .wake_req     (wake_req),
        .reset_req    (reset_req),
        .flag_timeout (flag_timeout),
        .flag_stop    (flag_stop)
    );

    AST_EXC_ONLY_IN_EXC_MODE: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> ($past(resp_sel) == 1'b0)); // R6

    AST_NO_TIMEOUT_IN_DEBUG: assert property (@(posedge clk) disable iff (rst)
        ($past(debug_hold) && $past(wd_enable) && !$past(rst)) |-> !exc_req); // R5

endmodule

// File: tb/wdog_top_tb_top.sv
`timescale 1ns/1ps
module wdog_top_tb_top;

    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst;
    logic         wd_enable, tick, refresh, debug_hold, stop_mode, resp_sel, status_clr;
    logic [W-1:0] reload_val;
    logic         exc_req, wake_req, reset_req, flag_timeout, flag_stop;

    int checks = 0;
    int failures = 0;
    int steps = 0;
    int first_exc = -1;

    logic [W-1:0] m_cnt;
    logic         m_enq, m_exc, m_wake, m_rr, m_ft, m_fs;

    always #5 clk = ~clk;

    wdog_top dut_i (
        .clk(clk), .rst(rst), .wd_enable(wd_enable), .tick(tick),
        .reload_val(reload_val), .refresh(refresh), .debug_hold(debug_hold),
        .stop_mode(stop_mode), .resp_sel(resp_sel), .status_clr(status_clr),
        .exc_req(exc_req), .wake_req(wake_req), .reset_req(reset_req),
        .flag_timeout(flag_timeout), .flag_stop(flag_stop)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] next_count(input logic [W-1:0] c, input logic ld, input logic dec);
        if (ld) return reload_val;
        if (dec) return c - 1'b1;
        return c;
    endfunction

    task automatic model_edge();
        logic ev;
        ev = 1'b0;
        if (rst) begin
            m_cnt = 24'h00FFFF; m_enq = 1'b1;
            m_exc = 0; m_wake = 0; m_rr = 0; m_ft = 0; m_fs = 0;
        end else begin
            if (wd_enable) begin
                if (!m_enq || refresh || debug_hold) begin
                    m_cnt = next_count(m_cnt, 1'b1, 1'b0);
                end else if (tick) begin
                    ev = (m_cnt == 0);
                    m_cnt = next_count(m_cnt, ev, !ev);
                end
            end
            m_enq  = wd_enable;
            m_exc  = ev && !resp_sel;
            m_wake = ev && !resp_sel && stop_mode;
            m_rr   = m_rr || (ev && resp_sel);
            if (ev) m_ft = 1'b1; else if (status_clr) m_ft = 1'b0;
            if (ev && !resp_sel && stop_mode) m_fs = 1'b1; else if (status_clr) m_fs = 1'b0;
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        steps++;
        @(negedge clk);
        if (exc_req && first_exc < 0) first_exc = steps;
        check("R6", "exc_req", exc_req, m_exc);
        check("R7", "wake_req", wake_req, m_wake);
        check("R8", "reset_req", reset_req, m_rr);
        check("R9", "flag_timeout", flag_timeout, m_ft);
        check("R7", "flag_stop", flag_stop, m_fs);
    endtask

    task automatic idle_inputs();
        wd_enable = 0; tick = 0; refresh = 0; debug_hold = 0;
        stop_mode = 0; resp_sel = 0; status_clr = 0; reload_val = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle_inputs();
        // R1: enable held through reset, count from reset value
        rst = 1; wd_enable = 1; tick = 1; reload_val = 24'd5;
        cyc(); cyc();
        check("R1", "reset outputs", {exc_req, wake_req, reset_req, flag_timeout, flag_stop}, 0);
        rst = 0; steps = 0; first_exc = -1;
        while (first_exc < 0 && steps < 70000) cyc();
        check("R1", "first timeout tick", first_exc, 65536);

        // R2 + R3: rising enable loads 3, timeout on 4th tick, repeating
        rst = 1; wd_enable = 0; cyc(); rst = 0;
        reload_val = 24'd3; cyc();
        wd_enable = 1; cyc();
        steps = 0; first_exc = -1;
        repeat (10) cyc();
        check("R3", "timeout period", first_exc, 4);
        // R2: disabled holds
        wd_enable = 0; repeat (20) cyc();
        check("R2", "no exc while disabled", exc_req, 0);

        // R4: refresh coincides with zero tick
        reload_val = 24'd2; wd_enable = 1; cyc();   // load
        cyc(); cyc();                               // count 2->1->0
        refresh = 1; cyc(); refresh = 0;
        check("R4", "refresh beats timeout", exc_req, 0);

        // R5: debug hold
        debug_hold = 1; repeat (30) cyc();
        check("R5", "no timeout in debug", exc_req, 0);
        debug_hold = 0;

        // R7 + R9: stop timeout, clear same cycle keeps flag
        status_clr = 1; cyc(); status_clr = 0;
        stop_mode = 1; reload_val = 24'd0; refresh = 1; cyc(); refresh = 0;
        status_clr = 1; cyc(); status_clr = 0;
        check("R7", "wake on stop timeout", wake_req, 1);
        check("R9", "set wins over clear", flag_stop, 1);
        stop_mode = 0; tick = 0; status_clr = 1; cyc(); status_clr = 0;
        check("R9", "flags cleared", {flag_timeout, flag_stop}, 0);

        // R8: reset response
        resp_sel = 1; tick = 1; repeat (3) cyc();
        check("R8", "reset_req held", reset_req, 1);

        // random phase
        for (int i = 0; i < 8000; i++) begin
            rst        = ($urandom % 200) == 0 || (m_rr && ($urandom % 8) == 0);
            wd_enable  = ($urandom % 50) != 0;
            tick       = ($urandom % 10) < 7;
            refresh    = ($urandom % 25) == 0;
            debug_hold = ($urandom % 40) == 0;
            stop_mode  = ($urandom % 3) == 0;
            resp_sel   = ($urandom % 6) == 0;
            status_clr = ($urandom % 12) == 0;
            if (($urandom % 30) == 0) reload_val = W'($urandom % 16);
            cyc();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule